// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Register

This block keeps the status byte of a serial flash device and decides, command by command, whether a modifying operation may start. A command decoder gives it one-cycle strobes for set-write-enable, write-status, page program, sector erase, bulk erase and operation-complete. With these strobes it gives the target address, the byte offered for a status write, and the level of the external write-protect pin. In return the block gives the status byte that a read-status command shifts out, and a one-cycle grant pulse for each operation it accepts. A host finds out that a long operation has finished by polling the busy bit of that byte.

The byte holds a busy flag, a write-enable latch, a three-bit protection level and a status-lock bit. The protection level and the lock bit stand for non-volatile cells. They are modelled as flops that load parameter values at reset. A modifying command starts only when the device is idle and the latch is set, and only when the target lies outside the protected region. A refused command clears the latch and changes nothing else. The serial shifting and the array itself are outside this block.

Top module: `fsr_guard`

## Requirements
- R1: While reset is asserted and after it is released, the status byte equals {LOCK_RST, 2'b00, LVL_RST, 1'b0, 1'b0} (0x00 with default parameters), and all grant outputs are low.
- R2: A write-enable strobe while bit 0 (busy) is 0 sets bit 1 (latch) from the next cycle. While busy is 1 the strobe is ignored.
- R3: A program, sector-erase, bulk-erase or write-status strobe is refused when busy is 1 or the latch is 0. A refusal raises no grant, leaves busy and bits 7 and 4:2 unchanged, and clears the latch.
- R4: An accepted command raises its own grant (grant_wrsr, grant_prog, grant_sect or grant_bulk) for exactly the cycle after the strobe, and sets busy from that cycle on.
- R5: An operation-complete strobe while busy is 1 clears busy and the latch from the next cycle. While busy is 0 the strobe has no effect.
- R6: An accepted write-status copies bit 7 (lock) and bits 4:2 (protection level) of the offered byte into the status byte when its completion arrives. Bits 6:5 always read 0.
- R7: When the lock bit is 1 and wp_n is 0, a write-status is refused. With wp_n at 1, or with lock at 0, it is accepted.
- R8: For a protection level k from 1 to 6, a program is refused when the top 7-k address bits are all ones, which is the top 1/2^(7-k) of the array. Elsewhere it is accepted.
- R9: A sector erase is refused when the last byte of the 2^SECT_W-byte sector that holds the address lies in the protected region.
- R10: A bulk erase is refused whenever the protection level is nonzero, and accepted at level 0.
- R11: Level 7 protects every address. Level 0 protects none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_sect | input | 1 | Sector erase strobe |
| cmd_bulk | input | 1 | Bulk erase strobe |
| op_done | input | 1 | Operation-complete strobe from the array sequencer |
| addr | input | ADDR_W | Target byte address of a program or sector erase |
| wrsr_val | input | 8 | Byte offered by a write-status command |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte {lock, 0, 0, level[2:0], latch, busy} |
| grant_wrsr | output | 1 | Write-status accepted pulse |
| grant_prog | output | 1 | Program accepted pulse |
| grant_sect | output | 1 | Sector erase accepted pulse |
| grant_bulk | output | 1 | Bulk erase accepted pulse |

## Verification
A corrupted latch or busy flag shows in the status byte one cycle after the strobe that caused it. It also changes whether the next modifying strobe is granted, so the grant in the following cycle shows it too. A wrong protection level stays hidden in the array until a write-status completes, and then shows in bits 4:2 at once. Address steps placed on both sides of each region edge, and a sector that straddles the edge, expose a wrong region decode on the first grant that should or should not appear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int LVL_W = 3;
  localparam int NLVL  = (1 << LVL_W) - 1;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WRSR = 3'd1,
    OP_PROG = 3'd2,
    OP_SECT = 3'd3,
    OP_BULK = 3'd4
  } op_e;

  typedef struct packed {
    logic             lock;
    logic [1:0]       rsvd;
    logic [LVL_W-1:0] lvl;
    logic             latch;
    logic             busy;
  } stat_t;
endpackage

// File: rtl/fsr_region_chk.sv
module fsr_region_chk
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  lvl,
  output logic              hit
);
  logic [NLVL:0] lvl_hit;

  assign lvl_hit[0]    = 1'b0;
  assign lvl_hit[NLVL] = 1'b1;

  generate
    for (genvar k = 1; k < NLVL; k++) begin : g_lvl
      localparam int TOPB = NLVL - k;
      assign lvl_hit[k] = &addr[ADDR_W-1 -: TOPB];
    end
  endgenerate

  always_comb hit = lvl_hit[lvl];

  always_comb begin
    if (lvl == '1) a_r11_full_cover : assert (hit);
    if (lvl == '0) a_r11_no_cover : assert (!hit);
  end
endmodule

// File: rtl/fsr_arbiter.sv
module fsr_arbiter
  import fsr_pkg::*;
(
  input  logic             cmd_wrsr,
  input  logic             cmd_prog,
  input  logic             cmd_sect,
  input  logic             cmd_bulk,
  input  logic             busy,
  input  logic             latch,
  input  logic             lock,
  input  logic [LVL_W-1:0] lvl,
  input  logic             wp_n,
  input  logic             prog_hit,
  input  logic             sect_hit,
  output op_e              acc_op,
  output logic             refuse
);
  logic want;
  logic hw_lock;
  logic gate_ok;

  always_comb begin
    want    = cmd_wrsr | cmd_prog | cmd_sect | cmd_bulk;
    hw_lock = lock & ~wp_n;
    gate_ok = ~busy & latch;
    acc_op  = OP_NONE;
    if (gate_ok) begin
      if (cmd_wrsr) begin
        if (!hw_lock) acc_op = OP_WRSR;
      end else if (cmd_prog) begin
        if (!prog_hit) acc_op = OP_PROG;
      end else if (cmd_sect) begin
        if (!sect_hit) acc_op = OP_SECT;
      end else if (cmd_bulk) begin
        if (lvl == '0) acc_op = OP_BULK;
      end
    end
    refuse = want && (acc_op == OP_NONE);
  end
endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
  import fsr_pkg::*;
#(
  parameter int              ADDR_W   = 19,
  parameter int              SECT_W   = 16,
  parameter logic [LVL_W-1:0] LVL_RST = '0,
  parameter logic            LOCK_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrsr,
  input  logic              cmd_prog,
  input  logic              cmd_sect,
  input  logic              cmd_bulk,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrsr_val,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              grant_wrsr,
  output logic              grant_prog,
  output logic              grant_sect,
  output logic              grant_bulk
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_W) - 64'd1);
  localparam int PEND_W = LVL_W + 1;

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // state
  logic              busy_q,  busy_d;
  logic              latch_q, latch_d;
  logic [LVL_W-1:0]  lvl_q,   lvl_d;
  logic              lock_q,  lock_d;
  logic [PEND_W-1:0] pend_q,  pend_d;
  op_e               op_q,    op_d;
  logic [3:0]        grant_q, grant_d;
  logic              st_en;

  // protection decode
  logic [ADDR_W-1:0] sect_last;
  logic              prog_hit;
  logic              sect_hit;
  op_e               acc_op;
  logic              refuse;

  assign sect_last = addr | SECT_MASK;

  fsr_region_chk #(.ADDR_W(ADDR_W)) u_prog_chk (
    .addr (addr),
    .lvl  (lvl_q),
    .hit  (prog_hit)
  );

  fsr_region_chk #(.ADDR_W(ADDR_W)) u_sect_chk (
    .addr (sect_last),
    .lvl  (lvl_q),
    .hit  (sect_hit)
  );

  fsr_arbiter u_arb (
    .cmd_wrsr (cmd_wrsr),
    .cmd_prog (cmd_prog),
    .cmd_sect (cmd_sect),
    .cmd_bulk (cmd_bulk),
    .busy     (busy_q),
    .latch    (latch_q),
    .lock     (lock_q),
    .lvl      (lvl_q),
    .wp_n     (wp_n),
    .prog_hit (prog_hit),
    .sect_hit (sect_hit),
    .acc_op   (acc_op),
    .refuse   (refuse)
  );

  // next state
  always_comb begin
    busy_d  = busy_q;
    latch_d = latch_q;
    lvl_d   = lvl_q;
    lock_d  = lock_q;
    pend_d  = pend_q;
    op_d    = op_q;
    grant_d = '0;
    st_en   = cmd_wren | cmd_wrsr | cmd_prog | cmd_sect | cmd_bulk
            | op_done | (|grant_q);

    if (cmd_wren && !busy_q) latch_d = 1'b1;
    if (refuse)              latch_d = 1'b0;

    if (acc_op != OP_NONE) begin
      busy_d = 1'b1;
      op_d   = acc_op;
      unique case (acc_op)
        OP_WRSR: begin
          grant_d[3] = 1'b1;
          pend_d     = {wrsr_val[7], wrsr_val[4:2]};
        end
        OP_PROG: grant_d[2] = 1'b1;
        OP_SECT: grant_d[1] = 1'b1;
        OP_BULK: grant_d[0] = 1'b1;
        default: grant_d    = '0;
      endcase
    end

    if (op_done && busy_q) begin
      busy_d  = 1'b0;
      latch_d = 1'b0;
      op_d    = OP_NONE;
      if (op_q == OP_WRSR) {lock_d, lvl_d} = pend_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      latch_q <= 1'b0;
      lvl_q   <= LVL_RST;
      lock_q  <= LOCK_RST;
      pend_q  <= '0;
      op_q    <= OP_NONE;
      grant_q <= '0;
    end else if (st_en) begin
      busy_q  <= busy_d;
      latch_q <= latch_d;
      lvl_q   <= lvl_d;
      lock_q  <= lock_d;
      pend_q  <= pend_d;
      op_q    <= op_d;
      grant_q <= grant_d;
    end
  end

  stat_t st;
  always_comb begin
    st.lock  = lock_q;
    st.rsvd  = 2'b00;
    st.lvl   = lvl_q;
    st.latch = latch_q;
    st.busy  = busy_q;
  end

  assign status     = st;
  assign grant_wrsr = grant_q[3];
  assign grant_prog = grant_q[2];
  assign grant_sect = grant_q[1];
  assign grant_bulk = grant_q[0];

  // checks
  a_r4_one_grant : assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({grant_wrsr, grant_prog, grant_sect, grant_bulk}));

  a_r4_grant_from_idle : assert property (@(posedge clk) disable iff (!rst_ni)
    (grant_wrsr | grant_prog | grant_sect | grant_bulk) |-> (busy_q && !$past(busy_q)));

  a_r3_no_latch_no_start : assert property (@(posedge clk) disable iff (!rst_ni)
    ((cmd_wrsr | cmd_prog | cmd_sect | cmd_bulk) && !latch_q && !busy_q) |=> !busy_q);

  a_r5_done_clears : assert property (@(posedge clk) disable iff (!rst_ni)
    (op_done && busy_q) |=> (!busy_q && !latch_q));

  a_r2_wren_sets : assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wren && !busy_q && !(cmd_wrsr | cmd_prog | cmd_sect | cmd_bulk)) |=> latch_q);

  a_r7_lock_frozen : assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_q && !wp_n && !busy_q) |=> ($stable(lvl_q) && $stable(lock_q)));

  a_r10_bulk_level : assert property (@(posedge clk) disable iff (!rst_ni)
    grant_bulk |-> (lvl_q == '0));

  a_r6_rsvd_zero : assert property (@(posedge clk) disable iff (!rst_ni)
    status[6:5] == 2'b00);
endmodule

// File: tb/sim_fsr_guard.sv
module sim_fsr_guard;
  logic        clk;
  logic        rst_n;
  logic        cmd_wren, cmd_wrsr, cmd_prog, cmd_sect, cmd_bulk, op_done;
  logic [18:0] addr;
  logic [7:0]  wrsr_val;
  logic        wp_n;
  logic [7:0]  status;
  logic        grant_wrsr, grant_prog, grant_sect, grant_bulk;

  int n_chk = 0;
  int n_bad = 0;

  fsr_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(cmd_wren), .cmd_wrsr(cmd_wrsr), .cmd_prog(cmd_prog),
    .cmd_sect(cmd_sect), .cmd_bulk(cmd_bulk), .op_done(op_done),
    .addr(addr), .wrsr_val(wrsr_val), .wp_n(wp_n),
    .status(status), .grant_wrsr(grant_wrsr), .grant_prog(grant_prog),
    .grant_sect(grant_sect), .grant_bulk(grant_bulk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: req[4] cmd[6]{wren,wrsr,prog,sect,bulk,done} wp_n addr[19] val[8] status[8] grant[4]{wrsr,prog,sect,bulk}
  localparam int NV = 42;
  localparam logic [49:0] VEC [NV] = '{
    {4'd3,  6'b001000, 1'b1, 19'h00000, 8'h00, 8'h00, 4'b0000}, // R3 no latch
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h02, 4'b0000}, // R2
    {4'd4,  6'b001000, 1'b1, 19'h00000, 8'h00, 8'h03, 4'b0100}, // R4 / R11 level 0
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h03, 4'b0000}, // R2 ignored while busy
    {4'd3,  6'b001000, 1'b1, 19'h00000, 8'h00, 8'h01, 4'b0000}, // R3 busy refusal
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h00, 4'b0000}, // R5
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h00, 4'b0000}, // R5 idle done
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h02, 4'b0000},
    {4'd4,  6'b010000, 1'b1, 19'h00000, 8'h98, 8'h03, 4'b1000}, // R4 wrsr
    {4'd6,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h98, 4'b0000}, // R6 commit
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd8,  6'b001000, 1'b1, 19'h3FFFF, 8'h00, 8'h9B, 4'b0100}, // R8 below half
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h98, 4'b0000},
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd8,  6'b001000, 1'b1, 19'h40000, 8'h00, 8'h98, 4'b0000}, // R8 in top half
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd10, 6'b000010, 1'b1, 19'h00000, 8'h00, 8'h98, 4'b0000}, // R10 refused
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd9,  6'b000100, 1'b1, 19'h30000, 8'h00, 8'h9B, 4'b0010}, // R9 clear sector
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h98, 4'b0000},
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd9,  6'b000100, 1'b1, 19'h40000, 8'h00, 8'h98, 4'b0000}, // R9 protected sector
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd7,  6'b010000, 1'b0, 19'h00000, 8'h00, 8'h98, 4'b0000}, // R7 hw lock
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h9A, 4'b0000},
    {4'd7,  6'b010000, 1'b1, 19'h00000, 8'h1C, 8'h9B, 4'b1000}, // R7 pin high
    {4'd6,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h1C, 4'b0000}, // R6
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h1E, 4'b0000},
    {4'd11, 6'b001000, 1'b1, 19'h00000, 8'h00, 8'h1C, 4'b0000}, // R11 level 7
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h1E, 4'b0000},
    {4'd7,  6'b010000, 1'b0, 19'h00000, 8'h64, 8'h1F, 4'b1000}, // R7 lock clear
    {4'd6,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h04, 4'b0000}, // R6 bits 6:5 dropped
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h06, 4'b0000},
    {4'd8,  6'b001000, 1'b1, 19'h7DFFF, 8'h00, 8'h07, 4'b0100}, // R8 below 1/64
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h04, 4'b0000},
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h06, 4'b0000},
    {4'd8,  6'b001000, 1'b1, 19'h7E000, 8'h00, 8'h04, 4'b0000}, // R8 edge of 1/64
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h06, 4'b0000},
    {4'd9,  6'b000100, 1'b1, 19'h70000, 8'h00, 8'h04, 4'b0000}, // R9 straddling
    {4'd2,  6'b100000, 1'b1, 19'h00000, 8'h00, 8'h06, 4'b0000},
    {4'd9,  6'b000100, 1'b1, 19'h60000, 8'h00, 8'h07, 4'b0010}, // R9 below
    {4'd5,  6'b000001, 1'b1, 19'h00000, 8'h00, 8'h04, 4'b0000}
  };

  task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic wp, input logic [18:0] a, input logic [7:0] v);
    {cmd_wren, cmd_wrsr, cmd_prog, cmd_sect, cmd_bulk, op_done} = c;
    wp_n = wp; addr = a; wrsr_val = v;
  endtask

  function automatic logic [7:0] grants();
    return {4'b0, grant_wrsr, grant_prog, grant_sect, grant_bulk};
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(6'b0, 1'b1, '0, '0);
    repeat (3) @(negedge clk);
    check(1, "status in reset R1", status, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, "status after reset R1", status, 8'h00);
    check(1, "grants after reset R1", grants(), 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][45:40], VEC[i][39], VEC[i][38:20], VEC[i][19:12]);
      @(negedge clk);
      check(int'(VEC[i][49:46]), $sformatf("vec %0d status", i), status, VEC[i][11:4]);
      check(int'(VEC[i][49:46]), $sformatf("vec %0d grant", i), grants(), {4'b0, VEC[i][3:0]});
    end

    // R1: reset mid-operation returns everything to reset values
    drive(6'b100000, 1'b1, '0, '0); @(negedge clk);
    drive(6'b001000, 1'b1, 19'h00000, '0); @(negedge clk);
    check(8, "prog at level 1 low addr", grants(), 8'h04);
    drive(6'b0, 1'b1, '0, '0);
    rst_n = 1'b0;
    #1;
    check(1, "async reset mid-op R1", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, "post reset R1", status, 8'h00);

    // R10: bulk erase accepted at level 0
    drive(6'b100000, 1'b1, '0, '0); @(negedge clk);
    drive(6'b000010, 1'b1, '0, '0); @(negedge clk);
    check(10, "bulk level0 status", status, 8'h03);
    check(10, "bulk level0 grant", grants(), 8'h01);
    drive(6'b000000, 1'b1, '0, '0); @(negedge clk);
    check(4, "grant one cycle only", grants(), 8'h00);
    drive(6'b000001, 1'b1, '0, '0); @(negedge clk);
    check(5, "bulk done", status, 8'h00);
    drive(6'b0, 1'b1, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule